// File: doc/BRIEF.md
# Base-Bounds Virtual Address Translator

This block turns a 32-bit virtual address into a physical address for a small embedded processor core that has no TLB. The address space is cut into four fixed regions by the top three address bits. The lower half is the user region, which is reachable from either privilege level. It is relocated and limited by a base/limit register pair. Instruction fetches and data accesses each have their own pair. The upper half holds three kernel-only regions. Two of them are windows onto the low 512 MB of physical memory, one cacheable and one uncacheable. The third passes the address through unchanged.

Each access is presented with a valid strobe, its kind (fetch, load or store) and the current privilege level. One cycle later the block returns the physical address, a cacheable attribute and an error flag. A separate register holds the last virtual address that produced an error. The four relocation registers are loaded through a small write port selected by a 2-bit index. The asynchronous active-low reset is released through an internal synchronizer.

Top module: `vaddr_xlate`

## Requirements
- R1: For an address with bit 31 clear that is below the selected limit, the response is physical address = virtual + selected base (modulo 2^32), cacheable = 1, error = 0, in either privilege level.
- R2: For an address with bit 31 clear, the response is error = 1 when the address is greater than or equal to the selected limit. Kind 0 (fetch) selects the instruction pair. Kinds 1 (load), 2 (store) and 3 (treated as data) select the data pair.
- R3: In kernel level, addresses 0x80000000–0x9FFFFFFF give physical = virtual AND 0x1FFFFFFF, cacheable = 1, error = 0.
- R4: In kernel level, addresses 0xA0000000–0xBFFFFFFF give physical = virtual AND 0x1FFFFFFF, cacheable = 0, error = 0.
- R5: In kernel level, addresses 0xC0000000–0xFFFFFFFF give physical = virtual, cacheable = 1, error = 0.
- R6: In user level (req_kmode = 0), any address with bit 31 set gives error = 1.
- R7: An erroring response drives physical address 0 and cacheable 0. The faulting virtual address appears on rsp_badva in the same cycle as the error. rsp_badva holds its value across non-erroring responses.
- R8: Write index 0 = instruction base, 1 = instruction limit, 2 = data base, 3 = data limit. A write is used by accesses presented in later cycles. An access presented in the same cycle as a write uses the old value.
- R9: Reset clears all four relocation registers, rsp_paddr, rsp_cached, rsp_err and rsp_badva to 0 and rsp_valid to 0. The reset value of a zero limit makes every user-region access an error.
- R10: rsp_valid is 1 exactly one cycle after req_valid is 1. Without a request, rsp_valid is 0 and the other response outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 data |
| req_kmode | input | 1 | 1 = kernel level, 0 = user level |
| cfg_we | input | 1 | Relocation register write enable |
| cfg_sel | input | 2 | Relocation register index |
| cfg_wdata | input | 32 | Relocation register write data |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_cached | output | 1 | Cacheable attribute |
| rsp_err | output | 1 | Address error |
| rsp_badva | output | 32 | Last faulting virtual address |

## Verification
A corrupted relocation register shows up on the first user-region access of its stream, one cycle after that access. It appears either as a shifted physical address or as a wrong error decision at the limit. A stale or wrongly enabled fault-address register shows on rsp_badva in the cycle of the next error, or as a change during a clean response. The vectors probe both sides of each limit, both ends of each kernel window, and carry-out on relocation. A region decode fault is seen in the very next response.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam int unsigned VX_AW     = 32;
  localparam int unsigned VX_NCFG   = 4;
  localparam int unsigned VX_SEG_W  = 3;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_DATA  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEG_USER      = 2'd0,
    SEG_KCACHED   = 2'd1,
    SEG_KUNCACHED = 2'd2,
    SEG_KDIRECT   = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    CFG_IBASE  = 2'd0,
    CFG_ILIMIT = 2'd1,
    CFG_DBASE  = 2'd2,
    CFG_DLIMIT = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/vx_rstsync.sv
module vx_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vx_cfgregs.sv
module vx_cfgregs
  import vx_pkg::*;
#(
  parameter int unsigned AW = VX_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] ibase,
  output logic [AW-1:0] ilimit,
  output logic [AW-1:0] dbase,
  output logic [AW-1:0] dlimit
);
  logic [AW-1:0] reg_q [VX_NCFG];

  for (genvar g = 0; g < VX_NCFG; g++) begin : g_reg
    logic          hit;
    logic [AW-1:0] reg_d;

    always_comb begin
      hit   = we && (sel == 2'(g));
      reg_d = hit ? wdata : reg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   reg_q[g] <= '0;
      else if (hit) reg_q[g] <= reg_d;
    end

    // R8
    cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'(g)) |=> (reg_q[g] == $past(wdata)));
  end

  assign ibase  = reg_q[CFG_IBASE];
  assign ilimit = reg_q[CFG_ILIMIT];
  assign dbase  = reg_q[CFG_DBASE];
  assign dlimit = reg_q[CFG_DLIMIT];
endmodule

// File: rtl/vx_segdec.sv
module vx_segdec
  import vx_pkg::*;
(
  input  logic [VX_SEG_W-1:0] top_bits,
  input  logic                kmode,
  output seg_e                seg,
  output logic                kviol
);
  always_comb begin
    unique casez (top_bits)
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_KCACHED;
      3'b101:  seg = SEG_KUNCACHED;
      default: seg = SEG_KDIRECT;
    endcase
    kviol = !kmode && top_bits[VX_SEG_W-1];
  end
endmodule

// File: rtl/vx_umap.sv
module vx_umap
  import vx_pkg::*;
#(
  parameter int unsigned AW = VX_AW
) (
  input  logic [AW-1:0] vaddr,
  input  acc_kind_e     kind,
  input  logic [AW-1:0] ibase,
  input  logic [AW-1:0] ilimit,
  input  logic [AW-1:0] dbase,
  input  logic [AW-1:0] dlimit,
  output logic [AW-1:0] paddr,
  output logic          over
);
  logic [AW-1:0] base_sel;
  logic [AW-1:0] limit_sel;

  always_comb begin
    if (kind == K_FETCH) begin
      base_sel  = ibase;
      limit_sel = ilimit;
    end else begin
      base_sel  = dbase;
      limit_sel = dlimit;
    end
    over  = (vaddr >= limit_sel);
    paddr = vaddr + base_sel;
  end
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import vx_pkg::*;
#(
  parameter int unsigned AW = VX_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  input  logic          req_kmode,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_cached,
  output logic          rsp_err,
  output logic [AW-1:0] rsp_badva
);
  localparam int unsigned WIN_W = AW - VX_SEG_W;

  logic          rst_q_n;
  logic [AW-1:0] ibase, ilimit, dbase, dlimit;
  seg_e          seg;
  logic          kviol;
  logic [AW-1:0] u_paddr;
  logic          u_over;

  logic          nx_err, nx_cached, nx_valid;
  logic [AW-1:0] nx_paddr, nx_badva;
  logic          rsp_en, bad_en;

  vx_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  vx_cfgregs #(.AW(AW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .ibase  (ibase),
    .ilimit (ilimit),
    .dbase  (dbase),
    .dlimit (dlimit)
  );

  vx_segdec u_seg (
    .top_bits (req_vaddr[AW-1:WIN_W]),
    .kmode    (req_kmode),
    .seg      (seg),
    .kviol    (kviol)
  );

  vx_umap #(.AW(AW)) u_umap (
    .vaddr  (req_vaddr),
    .kind   (acc_kind_e'(req_kind)),
    .ibase  (ibase),
    .ilimit (ilimit),
    .dbase  (dbase),
    .dlimit (dlimit),
    .paddr  (u_paddr),
    .over   (u_over)
  );

  // next-state
  always_comb begin
    nx_err    = 1'b0;
    nx_cached = 1'b0;
    nx_paddr  = '0;
    unique case (seg)
      SEG_USER: begin
        if (u_over) nx_err = 1'b1;
        else begin
          nx_paddr  = u_paddr;
          nx_cached = 1'b1;
        end
      end
      SEG_KCACHED: begin
        nx_paddr  = {{VX_SEG_W{1'b0}}, req_vaddr[WIN_W-1:0]};
        nx_cached = 1'b1;
      end
      SEG_KUNCACHED: begin
        nx_paddr  = {{VX_SEG_W{1'b0}}, req_vaddr[WIN_W-1:0]};
        nx_cached = 1'b0;
      end
      default: begin
        nx_paddr  = req_vaddr;
        nx_cached = 1'b1;
      end
    endcase
    if (kviol) begin
      nx_err    = 1'b1;
      nx_paddr  = '0;
      nx_cached = 1'b0;
    end
    nx_valid = req_valid;
    rsp_en   = req_valid;
    bad_en   = req_valid && nx_err;
    nx_badva = req_vaddr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) rsp_valid <= 1'b0;
    else          rsp_valid <= nx_valid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_paddr  <= '0;
      rsp_cached <= 1'b0;
      rsp_err    <= 1'b0;
    end else if (rsp_en) begin
      rsp_paddr  <= nx_paddr;
      rsp_cached <= nx_cached;
      rsp_err    <= nx_err;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    rsp_badva <= '0;
    else if (bad_en) rsp_badva <= nx_badva;
  end

  // R6
  user_kseg_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && !req_kmode && req_vaddr[AW-1]) |=> (rsp_valid && rsp_err));

  // R4
  kseg_uncached_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_kmode && req_vaddr[AW-1:WIN_W] == 3'b101)
      |=> (!rsp_cached && !rsp_err && rsp_paddr[AW-1:WIN_W] == 3'b000));

  // R7
  badva_cap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && rsp_err) |-> (rsp_badva == $past(req_vaddr)));

  // R7
  badva_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(rsp_valid && rsp_err) |-> $stable(rsp_badva));

  // R10
  rsp_valid_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_err)));
endmodule

// File: tb/vaddr_xlate_test.sv
`timescale 1ns/1ps
module vaddr_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_kmode;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_cached;
  logic        rsp_err;
  logic [31:0] rsp_badva;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vaddr_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_kmode(req_kmode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_cached(rsp_cached), .rsp_err(rsp_err),
    .rsp_badva(rsp_badva)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  k;
    logic        km;
    logic [31:0] a;
    logic        err;
    logic        c;
    logic [31:0] pa;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, 1'b0, 32'h0000_0100, 1'b1, 1'b0, 32'h0,         8'd9}, // R9 zero limit
    '{1'b1, 2'd0, 1'b0, 32'h1000_0000, 1'b0, 1'b0, 32'h0,         8'd8}, // R8 ibase
    '{1'b1, 2'd1, 1'b0, 32'h0000_2000, 1'b0, 1'b0, 32'h0,         8'd8}, // R8 ilimit
    '{1'b1, 2'd2, 1'b0, 32'h2000_0000, 1'b0, 1'b0, 32'h0,         8'd8}, // R8 dbase
    '{1'b1, 2'd3, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 32'h0,         8'd8}, // R8 dlimit
    '{1'b0, 2'd0, 1'b0, 32'h0000_1FFF, 1'b0, 1'b1, 32'h1000_1FFF, 8'd1}, // R1
    '{1'b0, 2'd0, 1'b0, 32'h0000_2000, 1'b1, 1'b0, 32'h0,         8'd2}, // R2 at limit
    '{1'b0, 2'd1, 1'b0, 32'h0000_1000, 1'b1, 1'b0, 32'h0,         8'd2}, // R2 data limit
    '{1'b0, 2'd2, 1'b0, 32'h0000_0FFC, 1'b0, 1'b1, 32'h2000_0FFC, 8'd1}, // R1 store
    '{1'b0, 2'd1, 1'b1, 32'h0000_1800, 1'b1, 1'b0, 32'h0,         8'd2}, // R2 kernel level
    '{1'b0, 2'd3, 1'b0, 32'h0000_0800, 1'b0, 1'b1, 32'h2000_0800, 8'd2}, // R2 kind 3 data
    '{1'b0, 2'd1, 1'b1, 32'h8000_1234, 1'b0, 1'b1, 32'h0000_1234, 8'd3}, // R3
    '{1'b0, 2'd1, 1'b1, 32'h9FFF_FFFF, 1'b0, 1'b1, 32'h1FFF_FFFF, 8'd3}, // R3 top
    '{1'b0, 2'd0, 1'b1, 32'hA000_1234, 1'b0, 1'b0, 32'h0000_1234, 8'd4}, // R4
    '{1'b0, 2'd1, 1'b1, 32'hBFFF_FFFF, 1'b0, 1'b0, 32'h1FFF_FFFF, 8'd4}, // R4 top
    '{1'b0, 2'd2, 1'b1, 32'hC123_4567, 1'b0, 1'b1, 32'hC123_4567, 8'd5}, // R5
    '{1'b0, 2'd1, 1'b0, 32'h8000_0000, 1'b1, 1'b0, 32'h0,         8'd6}, // R6
    '{1'b0, 2'd0, 1'b0, 32'hA000_0000, 1'b1, 1'b0, 32'h0,         8'd6}, // R6
    '{1'b0, 2'd2, 1'b0, 32'hFFFF_FFFC, 1'b1, 1'b0, 32'h0,         8'd6}, // R6
    '{1'b1, 2'd0, 1'b0, 32'hFFFF_F000, 1'b0, 1'b0, 32'h0,         8'd8}, // R8 ibase wrap
    '{1'b1, 2'd1, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0, 32'h0,         8'd8}, // R8 ilimit
    '{1'b0, 2'd0, 1'b0, 32'h0000_2000, 1'b0, 1'b1, 32'h0000_1000, 8'd1}  // R1 wrap
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [1:0] k, input logic km, input logic [31:0] a);
    req_valid = 1'b1; req_kind = k; req_kmode = km; req_vaddr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    req_kmode = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "rst valid", {31'd0, rsp_valid}, 32'd0);
    check("R9", "rst paddr", rsp_paddr, 32'd0);
    check("R9", "rst badva", rsp_badva, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) cfg_write(TBL[i].k, TBL[i].a);
      else begin
        access(TBL[i].k, TBL[i].km, TBL[i].a);
        check($sformatf("R%0d", TBL[i].req), $sformatf("v%0d valid", i),
              {31'd0, rsp_valid}, 32'd1);
        check($sformatf("R%0d", TBL[i].req), $sformatf("v%0d err", i),
              {31'd0, rsp_err}, {31'd0, TBL[i].err});
        check($sformatf("R%0d", TBL[i].req), $sformatf("v%0d cached", i),
              {31'd0, rsp_cached}, {31'd0, TBL[i].c});
        check($sformatf("R%0d", TBL[i].req), $sformatf("v%0d paddr", i),
              rsp_paddr, TBL[i].pa);
      end
    end

    // R7 capture and hold of fault address
    access(2'd1, 1'b0, 32'h0000_5000);
    check("R7", "err", {31'd0, rsp_err}, 32'd1);
    check("R7", "badva capture", rsp_badva, 32'h0000_5000);
    access(2'd1, 1'b0, 32'h0000_0010);
    check("R7", "badva hold", rsp_badva, 32'h0000_5000);
    check("R1", "clean paddr", rsp_paddr, 32'h2000_0010);

    // R10 idle cycle holds outputs
    @(negedge clk);
    check("R10", "idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R10", "idle paddr held", rsp_paddr, 32'h2000_0010);

    // R8 same-cycle write uses old value, next access new
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h3000_0000;
    access(2'd1, 1'b1, 32'h0000_0010);
    cfg_we = 1'b0;
    check("R8", "same-cycle old base", rsp_paddr, 32'h2000_0010);
    access(2'd1, 1'b1, 32'h0000_0010);
    check("R8", "new base", rsp_paddr, 32'h3000_0010);

    // R9 mid-run reset
    rst_n = 1'b0;
    #1;
    check("R9", "rst valid", {31'd0, rsp_valid}, 32'd0);
    check("R9", "rst paddr", rsp_paddr, 32'd0);
    check("R9", "rst badva", rsp_badva, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(2'd1, 1'b1, 32'h0000_0010);
    check("R9", "limit cleared", {31'd0, rsp_err}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule